// File: doc/BRIEF.md
# Page-Wrapped Serial Flash Read Responder

This block is the device side of a serial flash read path. A host lowers chip select, clocks in an 8-bit command, a 24-bit address and 32 dummy clocks, and then receives a continuous byte stream on the serial output. The stream comes from an internal read-only page array of `PAGES` pages of `PAGE_BYTES` (264) bytes. An address counter advances once per byte. It rolls from the last byte of a page into the next page and from the end of the array back to page 0, with no idle clocks at either boundary. Raising chip select ends the transfer and releases the output.

All serial pins are brought into the `clk` domain through a two-flop synchronizer, so `clk` must run at least four times faster than SCK. Input bits are taken on SCK rising edges, and the output bit moves on SCK falling edges. SCK may idle either high or low. The state machine has six states:
- IDLE: chip select high.
- CMD: receiving the command.
- ADDR: receiving the address.
- DUMMY: counting the dummy clocks.
- STREAM: driving data.
- DISCARD: an unknown command was received.

Its transitions are:
- IDLE→CMD when chip select is seen low.
- CMD→ADDR on the 8th rise if the command is accepted.
- CMD→DISCARD on the 8th rise otherwise.
- ADDR→DUMMY on the 24th rise, which also loads the address counter.
- DUMMY→STREAM on the 32nd rise.
- Any state→IDLE whenever chip select is seen high.

Top module: `flash_cread_resp`

## Requirements
- R1: Only the commands 0x68 and 0xE8, sent MSB first, start a read. Any other command puts the block in DISCARD, and `spi_so_en` stays low until chip select rises.
- R2: The 24 address bits arrive MSB first. Bits 23..21 are ignored. Bits 20..9 give the page, which is taken modulo `PAGES`. Bits 8..0 give the starting byte.
- R3: `spi_so_en` stays low for all 32 dummy clocks. The first data bit is driven after the SCK fall that follows the 32nd dummy rise.
- R4: Data bytes go out MSB first from consecutive addresses. After byte 263 of a page, byte 0 of the next page follows with no gap.
- R5: After byte 263 of page `PAGES-1`, byte 0 of page 0 follows with no gap.
- R6: Within 3 `clk` cycles of `spi_cs_n` rising, `spi_so_en` is low. `spi_so` reads 0 whenever `spi_so_en` is low.
- R7: The decoder returns to IDLE whenever chip select is high, so each new chip-select low period starts a fresh command, even after an aborted or partial one.
- R8: A starting byte offset above 263 is clamped to 263.
- R9: SI is sampled on SCK rising edges. `spi_so` changes only after SCK falling edges. SCK may idle low or high.
- R10: The byte at page p, offset b is (29·p + 7·b + 0xA5) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, at least 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host, 0 when not enabled |
| spi_so_en | output | 1 | Output enable for the SO pad driver; low means high impedance |

## Verification
The assertions check on every cycle that:
- the output is released after chip select rises, and the decoder is back in IDLE;
- a discarded command never enables the output;
- the byte counter never leaves 0..263, and the page never leaves the array;
- each page step and array wrap lands on byte 0 of the right page;
- the output bit holds between SCK falls.

Only the bench scenarios can show:
- that the streamed values match the page contents;
- that exactly 32 dummy clocks pass before the first bit;
- that both command codes work;
- the address field split and the clamp;
- that an aborted frame leaves no trace in the next one.

// File: rtl/flash_cread_pkg.sv
package flash_cread_pkg;

    localparam int OPC_W        = 8;
    localparam int ADDR_BITS    = 24;
    localparam int DUMMY_BITS   = 32;
    localparam int PAGE_FIELD_W = 12;
    localparam int BYTE_FIELD_W = 9;
    localparam int CNT_W        = $clog2(DUMMY_BITS);
    // shift register keeps only the bits the address decode needs
    localparam int SH_W         = PAGE_FIELD_W + BYTE_FIELD_W - 1;

    // content generator: (PAT_PMUL*page + PAT_BMUL*byte + PAT_BASE) mod 256
    localparam int PAT_PMUL = 29;
    localparam int PAT_BMUL = 7;
    localparam int PAT_BASE = 165;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_STREAM,
        ST_DISCARD
    } rd_state_t;

endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end

endmodule

// File: rtl/flash_page_rom.sv
module flash_page_rom
    import flash_cread_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 264,
    localparam int DEPTH     = PAGES * PAGE_BYTES,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] idx,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam int PG = i / PAGE_BYTES;
        localparam int BY = i % PAGE_BYTES;
        assign mem[i] = 8'((PG * PAT_PMUL + BY * PAT_BMUL + PAT_BASE) % 256);
    end

    always_ff @(posedge clk) begin
        rdata <= mem[idx];
    end

endmodule

// File: rtl/flash_addr_ctr.sv
module flash_addr_ctr
    import flash_cread_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 264
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [PAGE_FIELD_W-1:0] page_in,
    input  logic [BYTE_FIELD_W-1:0] byte_in,
    input  logic                    adv,
    output logic [PAGE_FIELD_W-1:0] page_q,
    output logic [BYTE_FIELD_W-1:0] byte_q
);

    localparam logic [BYTE_FIELD_W-1:0] LAST_BYTE = BYTE_FIELD_W'(PAGE_BYTES - 1);
    localparam logic [PAGE_FIELD_W-1:0] LAST_PAGE = PAGE_FIELD_W'(PAGES - 1);

    logic [BYTE_FIELD_W-1:0] byte_clamped;
    logic [PAGE_FIELD_W-1:0] page_folded;

    assign byte_clamped = (byte_in > LAST_BYTE) ? LAST_BYTE : byte_in;
    assign page_folded  = page_in % PAGE_FIELD_W'(PAGES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            byte_q <= '0;
        end else if (load) begin
            page_q <= page_folded;
            byte_q <= byte_clamped;
        end else if (adv) begin
            if (byte_q == LAST_BYTE) begin
                byte_q <= '0;
                page_q <= (page_q == LAST_PAGE) ? '0 : page_q + 1'b1;
            end else begin
                byte_q <= byte_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_cread_resp.sv
module flash_cread_resp
    import flash_cread_pkg::*;
#(
    parameter int         PAGES      = 4,
    parameter int         PAGE_BYTES = 264,
    parameter logic [7:0] CMD_A      = 8'h68,
    parameter logic [7:0] CMD_B      = 8'hE8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_en
);

    localparam int ROM_AW = $clog2(PAGES * PAGE_BYTES);

    // pin synchronizer: {cs, sck, si}
    logic [2:0] pins_s;
    logic       cs_s, sck_s, si_s, sck_d;
    logic       sck_rise, sck_fall;

    flash_pin_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sck, spi_si}),
        .dout (pins_s)
    );

    assign {cs_s, sck_s, si_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    // decoder state
    rd_state_t         state, state_n;
    logic [CNT_W-1:0]  bit_cnt, phase_last;
    logic [SH_W-1:0]   shreg;
    logic              bit_last, cmd_ok, addr_load;
    logic [7:0]        cmd_word;
    logic [SH_W:0]     addr_word;

    always_comb begin
        unique case (state)
            ST_CMD:   phase_last = CNT_W'(OPC_W - 1);
            ST_ADDR:  phase_last = CNT_W'(ADDR_BITS - 1);
            ST_DUMMY: phase_last = CNT_W'(DUMMY_BITS - 1);
            default:  phase_last = '1;
        endcase
    end

    assign bit_last  = sck_rise && (bit_cnt == phase_last);
    assign cmd_word  = {shreg[6:0], si_s};
    assign cmd_ok    = (cmd_word == CMD_A) || (cmd_word == CMD_B);
    assign addr_word = {shreg, si_s};
    assign addr_load = (state == ST_ADDR) && bit_last && !cs_s;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (!cs_s)    state_n = ST_CMD;
            ST_CMD:     if (bit_last) state_n = cmd_ok ? ST_ADDR : ST_DISCARD;
            ST_ADDR:    if (bit_last) state_n = ST_DUMMY;
            ST_DUMMY:   if (bit_last) state_n = ST_STREAM;
            ST_STREAM:  state_n = ST_STREAM;
            ST_DISCARD: state_n = ST_DISCARD;
            default:    state_n = ST_IDLE;
        endcase
        if (cs_s) state_n = ST_IDLE;
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            state <= state_n;
            if (cs_s || (state_n != state)) bit_cnt <= '0;
            else if (sck_rise)              bit_cnt <= bit_cnt + 1'b1;
            if (sck_rise && !cs_s)          shreg   <= addr_word[SH_W-1:0];
        end
    end

    // address counter and page array
    logic [PAGE_FIELD_W-1:0] page_q;
    logic [BYTE_FIELD_W-1:0] byte_q;
    logic [ROM_AW-1:0]       rom_idx;
    logic [7:0]              rom_q;
    logic                    adv;
    logic [2:0]              dbit;

    assign adv = (state == ST_STREAM) && sck_fall && (dbit == 3'd0);

    flash_addr_ctr #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (addr_load),
        .page_in(addr_word[SH_W:BYTE_FIELD_W]),
        .byte_in(addr_word[BYTE_FIELD_W-1:0]),
        .adv    (adv),
        .page_q (page_q),
        .byte_q (byte_q)
    );

    assign rom_idx = ROM_AW'(int'(page_q) * PAGE_BYTES + int'(byte_q));

    flash_page_rom #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_rom (
        .clk  (clk),
        .idx  (rom_idx),
        .rdata(rom_q)
    );

    // output process
    logic       so_q;
    logic [6:0] out_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q   <= 1'b0;
            out_sr <= '0;
            dbit   <= '0;
        end else if (state != ST_STREAM) begin
            so_q <= 1'b0;
            dbit <= '0;
        end else if (sck_fall) begin
            if (dbit == 3'd0) begin
                so_q   <= rom_q[7];
                out_sr <= rom_q[6:0];
            end else begin
                so_q   <= out_sr[6];
                out_sr <= {out_sr[5:0], 1'b0};
            end
            dbit <= dbit + 1'b1;
        end
    end

    assign spi_so_en = (state == ST_STREAM);
    assign spi_so    = spi_so_en & so_q;

endmodule

// File: rtl/flash_cread_chk.sv
module flash_cread_chk
    import flash_cread_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 264
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cs_s,
    input logic                    sck_fall,
    input rd_state_t               state,
    input logic                    adv,
    input logic [PAGE_FIELD_W-1:0] page_q,
    input logic [BYTE_FIELD_W-1:0] byte_q,
    input logic                    spi_so,
    input logic                    spi_so_en
);

    localparam logic [BYTE_FIELD_W-1:0] LB = BYTE_FIELD_W'(PAGE_BYTES - 1);
    localparam logic [PAGE_FIELD_W-1:0] LP = PAGE_FIELD_W'(PAGES - 1);

    AST_SO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_so_en); // R6

    AST_IDLE_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state == ST_IDLE)); // R7

    AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD) |=> !spi_so_en); // R1

    AST_BYTE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= LB); // R8

    AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        page_q <= LP); // R2

    AST_NEXT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && byte_q == LB && page_q != LP) |=>
            (byte_q == '0 && page_q == $past(page_q) + 1'b1)); // R4

    AST_ARRAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && byte_q == LB && page_q == LP) |=>
            (byte_q == '0 && page_q == '0)); // R5

    AST_SO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !cs_s && !sck_fall) |=> $stable(spi_so)); // R9

endmodule

bind flash_cread_resp flash_cread_chk #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sck_fall (sck_fall),
    .state    (state),
    .adv      (adv),
    .page_q   (page_q),
    .byte_q   (byte_q),
    .spi_so   (spi_so),
    .spi_so_en(spi_so_en)
);

// File: tb/tb_flash_cread_resp.sv
module tb_flash_cread_resp;

    localparam int PAGES = 4;
    localparam int PB    = 264;
    localparam int H     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sck = 1'b0;
    logic spi_si = 1'b0;
    logic spi_so, spi_so_en;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flash_cread_resp #(.PAGES(PAGES), .PAGE_BYTES(PB)) dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_si(spi_si), .spi_so(spi_so), .spi_so_en(spi_so_en)
    );

    function automatic logic [7:0] exp_byte(input int p, input int b);
        return 8'((p * 29 + b * 7 + 165) % 256);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic so_v, output logic en_v);
        @(negedge clk);
        spi_sck = 1'b0;
        spi_si  = b;
        repeat (H) @(negedge clk);
        so_v = spi_so;
        en_v = spi_so_en;
        spi_sck = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic spi_begin(input logic idle_hi);
        @(negedge clk);
        spi_sck  = idle_hi;
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic spi_end(input logic idle_hi);
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        spi_sck = idle_hi;
        repeat (6) @(negedge clk);
    endtask

    // command + address + dummy; checks output stays off throughout (R3)
    task automatic send_header(input logic [7:0] cmd, input logic [23:0] addr);
        logic s, e;
        int en_seen = 0;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(cmd[i], s, e);
            en_seen += int'(e);
        end
        for (int i = 23; i >= 0; i--) begin
            spi_bit(addr[i], s, e);
            en_seen += int'(e);
        end
        for (int i = 0; i < 32; i++) begin
            spi_bit(1'b1, s, e);
            en_seen += int'(e);
        end
        chk(en_seen == 0, "R3 output off during header", en_seen, 0);
    endtask

    // read n bytes, expecting stream starting at page p, byte b (R4, R5, R10)
    task automatic read_check(input int n, input int p0, input int b0, input string req);
        int p = p0;
        int b = b0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] got;
            int en_cnt = 0;
            for (int j = 7; j >= 0; j--) begin
                logic s, e;
                spi_bit(1'b0, s, e);
                got[j] = s;
                en_cnt += int'(e);
            end
            chk(en_cnt == 8, {req, " R3 output enabled in data"}, en_cnt, 8);
            chk(got == exp_byte(p, b), {req, " R10 data byte"}, got, exp_byte(p, b));
            if (b == PB - 1) begin
                b = 0;
                p = (p == PAGES - 1) ? 0 : p + 1;
            end else begin
                b++;
            end
        end
    endtask

    function automatic logic [23:0] mk_addr(input logic [2:0] hi, input int pg, input int by);
        return {hi, 12'(pg), 9'(by)};
    endfunction

    task automatic t_reset();
        chk(spi_so_en == 1'b0, "R6 reset so_en", spi_so_en, 0);
        chk(spi_so == 1'b0, "R6 reset so", spi_so, 0);
    endtask

    task automatic t_basic_read();
        spi_begin(1'b0);
        send_header(8'h68, mk_addr(3'b000, 1, 5));
        read_check(4, 1, 5, "R1 R2 basic");
        spi_end(1'b0);
        chk(spi_so_en == 1'b0, "R6 released after read", spi_so_en, 0);
    endtask

    task automatic t_alt_cmd();
        // upper bits set, page field 6 folds to page 2 (R2)
        spi_begin(1'b0);
        send_header(8'hE8, mk_addr(3'b101, 6, 100));
        read_check(3, 2, 100, "R1 R2 alt command");
        spi_end(1'b0);
    endtask

    task automatic t_page_cross();
        spi_begin(1'b0);
        send_header(8'h68, mk_addr(3'b000, 0, 262));
        read_check(3, 0, 262, "R4 page cross");
        spi_end(1'b0);
    endtask

    task automatic t_array_wrap();
        spi_begin(1'b0);
        send_header(8'h68, mk_addr(3'b000, PAGES - 1, 263));
        read_check(2, PAGES - 1, 263, "R5 array wrap");
        spi_end(1'b0);
    endtask

    task automatic t_clamp();
        spi_begin(1'b0);
        send_header(8'h68, mk_addr(3'b000, 1, 300));
        read_check(2, 1, 263, "R8 clamp");
        spi_end(1'b0);
    endtask

    task automatic t_bad_cmd();
        logic s, e;
        int en_seen = 0;
        logic [7:0] bad = 8'h52;
        spi_begin(1'b0);
        for (int i = 7; i >= 0; i--) begin
            spi_bit(bad[i], s, e);
            en_seen += int'(e);
        end
        for (int i = 0; i < 80; i++) begin
            spi_bit(i[0], s, e);
            en_seen += int'(e);
        end
        chk(en_seen == 0, "R1 unknown command ignored", en_seen, 0);
        spi_end(1'b0);
        spi_begin(1'b0);
        send_header(8'h68, mk_addr(3'b000, 3, 10));
        read_check(1, 3, 10, "R7 after discard");
        spi_end(1'b0);
    endtask

    task automatic t_cs_abort();
        logic s, e;
        spi_begin(1'b0);
        send_header(8'h68, mk_addr(3'b000, 2, 0));
        read_check(1, 2, 0, "R4 before abort");
        for (int i = 0; i < 3; i++) spi_bit(1'b0, s, e);
        @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(spi_so_en == 1'b0, "R6 release on CS rise", spi_so_en, 0);
        chk(spi_so == 1'b0, "R6 so low when released", spi_so, 0);
        spi_sck = 1'b0;
        repeat (6) @(negedge clk);
        // partial command, then abort
        spi_begin(1'b0);
        for (int i = 0; i < 3; i++) spi_bit(1'b1, s, e);
        spi_end(1'b0);
        spi_begin(1'b0);
        send_header(8'hE8, mk_addr(3'b000, 0, 7));
        read_check(2, 0, 7, "R7 fresh frame after abort");
        spi_end(1'b0);
    endtask

    task automatic t_idle_high();
        spi_begin(1'b1);
        send_header(8'h68, mk_addr(3'b000, 2, 200));
        read_check(3, 2, 200, "R9 SCK idle high");
        spi_end(1'b1);
        spi_sck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_basic_read();
        t_alt_cmd();
        t_page_cross();
        t_array_wrap();
        t_clamp();
        t_bad_cmd();
        t_cs_abort();
        t_idle_high();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule